// File: doc/BRIEF.md
# Payload identifier packet inserter

This block writes a four-byte payload identifier ancillary packet into the horizontal blanking of a 10-bit video word stream. It assembles the whole packet itself. The packet has an ancillary flag, a data identifier, a secondary identifier, a data count, four payload words and a checksum. Only the four payload bytes come from host registers. A line number register for each field picks the line that carries the packet. An active-low control turns insertion on and off.

The packet is anchored by the video standard. In SD it follows the last word of the end-of-active-video sequence. In HD it follows the last line CRC word of the luma stream. Ancillary packets may already sit at that spot. The block then parses them and places its packet in the first free word after them. If fewer than eleven words remain before the next start-of-active-video sequence, the packet is dropped for that line. Every word that is not replaced leaves the block one clock after it entered.

Top module: `pid_inserter`

## Requirements
- R1: While `rst_n` is low, `vid_out` is 000h and no packet is started.
- R2: Every input word that is not replaced by the packet appears on `vid_out` exactly one clock later, unchanged.
- R3: The inserted packet is 11 consecutive words in this order:
  - 000h, 3FFh, 3FFh, then 241h, 101h, 104h.
  - Then payload words built from bytes `pid_lo[7:0]`, `pid_lo[15:8]`, `pid_hi[7:0]`, `pid_hi[15:8]`. Each payload word holds its byte in bits 7:0, even parity of that byte in bit 8, and the inverse of bit 8 in bit 9.
  - Then a checksum word. Its bits 8:0 are the 9-bit sum of bits 8:0 of the seven words from 241h through the last payload word, and its bit 9 is the inverse of its bit 8.
- R4: No packet is inserted while `ins_off` is high, or while all four payload bytes are zero.
- R5: The packet is inserted only on the line whose `line_num` equals `line_f1` when `field2` is 0, or `line_f2` when `field2` is 1.
- R6: With `sd_mode` high, the first candidate word is the one right after the word flagged by `eav_last`. With `sd_mode` low, it is the one right after the word flagged by `crc_last`, and `eav_last` is ignored.
- R7: A candidate word equal to 000h starts an existing ancillary packet. The block takes the low 8 bits of that packet's sixth word as its data count D. It skips D+7 words in total and then tests the next word as a candidate.
- R8: At the first free candidate word, the packet is inserted only if `sav_dist` (words left before the first SAV word, counting the current one) is at least 11. Otherwise the packet is dropped for that line.
- R9: When payload byte 2 has bit 6 set and bit 7 clear (`pid_lo[14]`=1, `pid_lo[15]`=0), the stream is treated as a segmented progressive frame. `line_f1` then selects the line in both fields and `line_f2` is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | 10 | Incoming video word (luma stream in HD) |
| sd_mode | input | 1 | 1 = SD stream, 0 = HD stream |
| line_num | input | 11 | Current line number from the timing counter |
| field2 | input | 1 | 1 while in the second field |
| eav_last | input | 1 | Flags the last word of the EAV sequence |
| crc_last | input | 1 | Flags the last line CRC word (HD) |
| sav_first | input | 1 | Flags the first word of the SAV sequence |
| sav_dist | input | 12 | Words remaining before the first SAV word, counting the current word |
| pid_lo | input | 16 | Payload bytes 2 (15:8) and 1 (7:0) |
| pid_hi | input | 16 | Payload bytes 4 (15:8) and 3 (7:0) |
| line_f1 | input | 11 | Insertion line for field 1 |
| line_f2 | input | 11 | Insertion line for field 2 |
| ins_off | input | 1 | High disables insertion |
| vid_out | output | 10 | Output video word, one clock behind `vid_in` |

## Verification
The bench builds the block with its default widths: 11-bit line numbers and a 12-bit blanking distance. These widths reach line numbers in the upper field, such as 272, and the eleven-word space limit in both directions. Lines are assembled with zero to two existing ancillary packets of chosen data counts. This drives the packet parser through several skips before insertion, and it puts the free slot at exactly 10 and exactly 11 words from SAV.

// File: rtl/pid_inserter.sv
module pid_inserter #(
  parameter int LINE_W = 11,
  parameter int DIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [9:0]        vid_in,
  input  logic              sd_mode,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field2,
  input  logic              eav_last,
  input  logic              crc_last,
  input  logic              sav_first,
  input  logic [DIST_W-1:0] sav_dist,
  input  logic [15:0]       pid_lo,
  input  logic [15:0]       pid_hi,
  input  logic [LINE_W-1:0] line_f1,
  input  logic [LINE_W-1:0] line_f2,
  input  logic              ins_off,
  output logic [9:0]        vid_out
);
  localparam int PKT_LEN = 11;
  localparam int HDR_LAST = 5;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_HDR, S_SKIP, S_INS} st_t;
  st_t st;
  logic [7:0] cnt;

  function automatic logic [9:0] pword(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  logic [9:0] pkt [PKT_LEN];
  logic [8:0] sum;
  always_comb begin
    pkt[0] = 10'h000;
    pkt[1] = 10'h3FF;
    pkt[2] = 10'h3FF;
    pkt[3] = 10'h241;
    pkt[4] = 10'h101;
    pkt[5] = 10'h104;
    pkt[6] = pword(pid_lo[7:0]);
    pkt[7] = pword(pid_lo[15:8]);
    pkt[8] = pword(pid_hi[7:0]);
    pkt[9] = pword(pid_hi[15:8]);
    sum = '0;
    for (int i = 3; i < PKT_LEN - 1; i++) sum = sum + pkt[i][8:0];
    pkt[PKT_LEN-1] = {~sum[8], sum};
  end

  wire anchor   = sd_mode ? eav_last : crc_last;
  wire psf      = pid_lo[14] & ~pid_lo[15];
  wire line_hit = (field2 && !psf) ? (line_num == line_f2) : (line_num == line_f1);
  wire enabled  = !ins_off && ((|pid_lo) || (|pid_hi));
  wire room     = sav_dist >= DIST_W'(PKT_LEN);
  wire free     = (st == S_SCAN) && (vid_in != 10'h000);
  wire start    = free && enabled && line_hit && room;
  wire ins_now  = start || (st == S_INS);
  wire [3:0] idx = (st == S_INS) ? cnt[3:0] : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      vid_out <= '0;
    end else begin
      vid_out <= ins_now ? pkt[idx] : vid_in;
      case (st)
        S_IDLE: if (anchor) st <= S_SCAN;
        S_SCAN: begin
          if (sav_first) st <= S_IDLE;
          else if (vid_in == 10'h000) begin
            st  <= S_HDR;
            cnt <= 8'd1;
          end else if (start) begin
            st  <= S_INS;
            cnt <= 8'd1;
          end else st <= S_IDLE;
        end
        S_HDR: begin
          if (sav_first) st <= S_IDLE;
          else if (cnt == 8'(HDR_LAST)) begin
            st  <= S_SKIP;
            cnt <= vid_in[7:0];
          end else cnt <= cnt + 8'd1;
        end
        S_SKIP: begin
          if (sav_first) st <= S_IDLE;
          else if (cnt == 8'd0) st <= S_SCAN;
          else cnt <= cnt - 8'd1;
        end
        S_INS: begin
          if (cnt == 8'(PKT_LEN - 1)) st <= S_IDLE;
          else cnt <= cnt + 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pid_inserter_chk #(
  parameter int DIST_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [9:0]        vid_in,
  input logic [9:0]        vid_out,
  input logic              ins_now,
  input logic              pkt_start,
  input logic [DIST_W-1:0] sav_dist,
  input logic              ins_off
);
  assert_rst_R1: assert property (@(posedge clk) !rst_n |=> vid_out == 10'h000);
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_now |=> vid_out == $past(vid_in));
  assert_adf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> vid_out == 10'h000);
  assert_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> !ins_off);
  assert_room_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> sav_dist >= DIST_W'(11));
endmodule

bind pid_inserter pid_inserter_chk #(.DIST_W(DIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .vid_out(vid_out),
  .ins_now(ins_now), .pkt_start(start), .sav_dist(sav_dist), .ins_off(ins_off)
);

// File: tb/test_pid_inserter.sv
`timescale 1ns/1ps
module test_pid_inserter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  vid_in = 10'h123;
  logic        sd_mode = 1;
  logic [10:0] line_num = '0;
  logic        field2 = 0;
  logic        eav_last = 0, crc_last = 0, sav_first = 0;
  logic [11:0] sav_dist = '0;
  logic [15:0] pid_lo = '0, pid_hi = '0;
  logic [10:0] line_f1 = '0, line_f2 = '0;
  logic        ins_off = 0;
  logic [9:0]  vid_out;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [9:0] w; string req; } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  pid_inserter i_pid_inserter (
    .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .sd_mode(sd_mode),
    .line_num(line_num), .field2(field2), .eav_last(eav_last),
    .crc_last(crc_last), .sav_first(sav_first), .sav_dist(sav_dist),
    .pid_lo(pid_lo), .pid_hi(pid_hi), .line_f1(line_f1), .line_f2(line_f2),
    .ins_off(ins_off), .vid_out(vid_out)
  );

  function automatic logic [9:0] pw(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  function automatic logic [9:0] exp_pkt(input int k);
    logic [9:0] p [4];
    logic [8:0] s;
    p[0] = pw(pid_lo[7:0]);  p[1] = pw(pid_lo[15:8]);
    p[2] = pw(pid_hi[7:0]);  p[3] = pw(pid_hi[15:8]);
    s = 9'h041 + 9'h101 + 9'h104 + p[0][8:0] + p[1][8:0] + p[2][8:0] + p[3][8:0];
    case (k)
      0: return 10'h000;
      1, 2: return 10'h3FF;
      3: return 10'h241;
      4: return 10'h101;
      5: return 10'h104;
      6, 7, 8, 9: return p[k-6];
      default: return {~s[8], s};
    endcase
  endfunction

  // monitor: compare each output word one clock after its input
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (vid_out !== it.w) begin
        bad++;
        $display("FAIL %s: vid_out=%h expected=%h", it.req, vid_out, it.w);
      end
    end
  end

  task automatic drive(input logic [9:0] w, input bit sf, input bit el, input bit cl,
                       input logic [11:0] d, input logic [9:0] e, input string r);
    item_t it;
    @(negedge clk);
    vid_in = w; sav_first = sf; eav_last = el; crc_last = cl; sav_dist = d;
    it.w = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic run_line(input bit sd, input int ln, input bit f2, input int n_anc,
                          input int dc, input int blank, input bit exp_ins, input string req);
    logic [9:0] ws[$];
    bit sfq[$], elq[$], clq[$];
    int anchor_i, free_i, sav_i;
    sd_mode = sd; line_num = 11'(ln); field2 = f2;
    for (int i = 0; i < 4; i++) begin ws.push_back(10'h123); sfq.push_back(0); elq.push_back(0); clq.push_back(0); end
    ws.push_back(10'h3FF); ws.push_back(10'h000); ws.push_back(10'h000); ws.push_back(10'h274);
    for (int i = 0; i < 4; i++) begin sfq.push_back(0); elq.push_back(i == 3); clq.push_back(0); end
    if (!sd) begin
      ws.push_back(10'h22C); ws.push_back(10'h200); ws.push_back(10'h155); ws.push_back(10'h0AA);
      for (int i = 0; i < 4; i++) begin sfq.push_back(0); elq.push_back(0); clq.push_back(i == 3); end
    end
    anchor_i = ws.size() - 1;
    for (int a = 0; a < n_anc; a++) begin
      ws.push_back(10'h000); ws.push_back(10'h3FF); ws.push_back(10'h3FF);
      ws.push_back(10'h180); ws.push_back(10'h200); ws.push_back(pw(8'(dc)));
      for (int j = 0; j < dc; j++) ws.push_back(10'h1AA);
      ws.push_back(10'h2AB);
    end
    free_i = ws.size();
    for (int i = 0; i < blank; i++) ws.push_back(10'h040);
    sav_i = ws.size();
    ws.push_back(10'h3FF); ws.push_back(10'h000); ws.push_back(10'h000); ws.push_back(10'h200);
    while (sfq.size() < ws.size()) begin
      sfq.push_back(sfq.size() == sav_i); elq.push_back(0); clq.push_back(0);
    end
    for (int i = 0; i < ws.size(); i++) begin
      logic [9:0] e;
      string r;
      logic [11:0] d;
      e = ws[i];
      r = exp_ins ? "R2" : req;
      if (exp_ins && i >= free_i && i < free_i + 11) begin
        e = exp_pkt(i - free_i);
        r = req;
      end
      d = (i > anchor_i && i <= sav_i) ? 12'(sav_i - i) : 12'd0;
      drive(ws[i], sfq[i], elq[i], clq[i], d, e, r);
    end
  endtask

  initial begin
    pid_lo = 16'h0689; pid_hi = 16'h0180;
    line_f1 = 11'd10; line_f2 = 11'd272;
    vid_in = 10'h2B5;
    repeat (3) @(negedge clk);
    total++;
    if (vid_out !== 10'h000) begin bad++; $display("FAIL R1: vid_out=%h expected=000", vid_out); end
    @(negedge clk); rst_n = 1;

    run_line(1, 10, 0, 0, 0, 20, 1, "R3 R6 SD basic insert");
    run_line(1, 272, 1, 0, 0, 20, 1, "R5 field2 line");
    run_line(1, 11, 0, 0, 0, 20, 0, "R5 wrong line");
    run_line(1, 10, 1, 0, 0, 20, 0, "R5 field2 uses own register");
    ins_off = 1;
    run_line(1, 10, 0, 0, 0, 20, 0, "R4 disabled");
    ins_off = 0;
    pid_lo = 16'h0000; pid_hi = 16'h0000;
    run_line(1, 10, 0, 0, 0, 20, 0, "R4 zero payload");
    pid_lo = 16'h06FF; pid_hi = 16'h3C01;
    run_line(1, 10, 0, 1, 3, 20, 1, "R7 after one packet");
    run_line(1, 10, 0, 2, 2, 20, 1, "R7 after two packets");
    run_line(1, 10, 0, 1, 0, 15, 1, "R7 zero count packet");
    run_line(1, 10, 0, 0, 0, 10, 0, "R8 ten words short");
    run_line(1, 10, 0, 0, 0, 11, 1, "R8 exactly eleven");
    run_line(1, 10, 0, 1, 4, 8, 0, "R8 short after packet");
    run_line(0, 10, 0, 0, 0, 20, 1, "R6 HD after CRC");
    run_line(0, 10, 0, 1, 1, 20, 1, "R6 R7 HD after packet");
    pid_lo = 16'h4A89;
    run_line(1, 10, 1, 0, 0, 20, 1, "R9 segmented uses field1 line");
    run_line(1, 272, 1, 0, 0, 20, 0, "R9 field2 register unused");
    pid_lo = 16'hCA89;
    run_line(1, 272, 1, 0, 0, 20, 1, "R9 R5 interlaced bits keep field2");
    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: expected=finished actual=hung");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule